// File: doc/BRIEF.md
# Mailbox Send Unit with Per-Target Delivery Tracking

This block is the transmit half of an inter-processor mailbox. A CPU uses a small 32-bit register interface to load a 64-bit message and a target number. It then writes a trigger, and the block hands the message to that target's receive port as a one-cycle strobe with the message beside it. The block keeps four flags for each target:

- **pending**: the message was sent but has not been fetched yet.
- **fetched**: the target has taken the message.
- **collision**: a send was attempted while a message was still pending.
- **stalled**: a send was attempted while the target's receive port reported full.

Each flag group has its own status byte. Software clears the sticky groups (fetched, collision, stalled) by writing 1 to the matching bits. Three group summaries can each raise a maskable interrupt. A target reports a fetch with a one-cycle pulse and a target number. That pulse retires the pending flag of that target and records the fetch.

A trigger resolves in this priority: a pending target first gives a collision, then a full receive port gives a stall, otherwise the message is sent. A message that is not sent is dropped.

Top module: `mbox_send_unit`

## Requirements
- R1: After reset the status word (0x14) reads 0, the interrupt status (0x18) reads 0, the mask (0x1C) reads 3'b111, `irq_o` is 0 and no `tgt_valid_o` bit is set.
- R2: The target register (0x00, 3 bits), the low word (0x04) and the high word (0x08) read back what was last written.
- R3: A write to 0x0C with bit 0 set, for a target that is not pending and not full, drives `tgt_valid_o[id]` high for exactly the next cycle, with `tgt_msg_o = {high, low}`, and sets status bit `id` (pending, bits 7:0). A write to 0x0C with bit 0 clear has no effect.
- R4: A trigger to a pending target sets its collision bit (status bits 15:8). It drives no strobe and leaves the pending bit set.
- R5: A trigger to a target that is not pending but has `tgt_full_i[id]` high sets its stalled bit (status bits 31:24) and drives no strobe.
- R6: A fetch pulse for a pending target clears its pending bit and sets its fetched bit (status bits 23:16). A fetch for a target that is not pending changes nothing.
- R7: A write to 0x10 clears each fetched, collision and stalled bit written as 1, in the same bit positions as the status word. Pending bits are unaffected and 0x10 reads 0.
- R8: The interrupt sources are: stalled (any of bits 31:24, mask bit 0), collision (any of bits 15:8, mask bit 1) and fetched (any of bits 23:16, mask bit 2). The pending interrupt sets on the cycle after an unmasked source becomes active. A masked source never sets it, and unmasking a source that is already active sets it.
- R9: `irq_o` equals bit 0 of the interrupt status (0x18). Writing 1 to that bit clears it.
- R10: Mask bits 2:0 at 0x1C are read-write, and a 1 masks the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| tgt_valid_o | output | 8 | One-hot strobe, one bit per target |
| tgt_msg_o | output | 64 | Message sent with the strobe |
| tgt_full_i | input | 8 | Receive port full, one bit per target |
| fetch_i | input | 1 | Fetch pulse from a target |
| fetch_id_i | input | 3 | Number of the fetching target |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pending flag shows up in two ways: a missing or extra strobe on the very next trigger to that target, or a collision bit that should not be there. Both are visible in the status read on the cycle after that trigger. A lost fetched, collision or stalled bit shows in the status word right after the event. It also shows one cycle later as an interrupt that does not rise. A bad mask or edge detector shows as `irq_o` differing from the expected level one cycle after the flag change. Random mixes of triggers, fetches, clears and port-full changes are compared against a flag model after every operation.

// File: rtl/mbox_send_pkg.sv
package mbox_send_pkg;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned N_SRC   = 3;

  localparam logic [ADDR_W-1:0] A_ID    = 6'h00;
  localparam logic [ADDR_W-1:0] A_LO    = 6'h04;
  localparam logic [ADDR_W-1:0] A_HI    = 6'h08;
  localparam logic [ADDR_W-1:0] A_TRIG  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_CLR   = 6'h10;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] A_IRQ   = 6'h18;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'h1C;

  typedef enum logic [1:0] {
    SRC_STALL   = 2'd0,
    SRC_COLLIDE = 2'd1,
    SRC_FETCHED = 2'd2
  } irq_src_e;

  // byte lanes of the status word, MSB first
  typedef struct packed {
    logic [FIELD_W-1:0] stall;
    logic [FIELD_W-1:0] fetched;
    logic [FIELD_W-1:0] collide;
    logic [FIELD_W-1:0] pending;
  } status_t;
endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_send_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned MSG_W   = 64,
  localparam int unsigned ID_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ID_W-1:0]   id_o,
  output logic [MSG_W-1:0]  msg_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic              trig_o,
  output logic              clr_o,
  output logic              irq_clr_o,
  input  status_t           status_i,
  input  logic              pend_i
);
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [N_SRC-1:0]  mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      mask_q <= '1;
    end else if (wr_en_i) begin
      case (addr_i)
        A_ID:   id_q   <= wdata_i[ID_W-1:0];
        A_LO:   lo_q   <= wdata_i;
        A_HI:   hi_q   <= wdata_i;
        A_MASK: mask_q <= wdata_i[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  assign trig_o    = wr_en_i && (addr_i == A_TRIG) && wdata_i[0];
  assign clr_o     = wr_en_i && (addr_i == A_CLR);
  assign irq_clr_o = wr_en_i && (addr_i == A_IRQ) && wdata_i[0];
  assign id_o      = id_q;
  assign msg_o     = {hi_q, lo_q};
  assign mask_o    = mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_ID:   rdata_o[ID_W-1:0]  = id_q;
      A_LO:   rdata_o            = lo_q;
      A_HI:   rdata_o            = hi_q;
      A_STAT: rdata_o            = status_i;
      A_IRQ:  rdata_o[0]         = pend_i;
      A_MASK: rdata_o[N_SRC-1:0] = mask_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mbox_tgt_track.sv
module mbox_tgt_track #(
  parameter int unsigned NUM_TGT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TGT-1:0] trig_sel_i,
  input  logic [NUM_TGT-1:0] full_i,
  input  logic [NUM_TGT-1:0] fetch_sel_i,
  input  logic [NUM_TGT-1:0] clr_fetched_i,
  input  logic [NUM_TGT-1:0] clr_collide_i,
  input  logic [NUM_TGT-1:0] clr_stall_i,
  output logic [NUM_TGT-1:0] send_o,
  output logic [NUM_TGT-1:0] pending_o,
  output logic [NUM_TGT-1:0] fetched_o,
  output logic [NUM_TGT-1:0] collide_o,
  output logic [NUM_TGT-1:0] stall_o
);
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic send, col_set, stl_set, hit;
    logic pend_q, fet_q, col_q, stl_q;

    // collision outranks stall, stall outranks send
    assign col_set = trig_sel_i[t] & pend_q;
    assign stl_set = trig_sel_i[t] & ~pend_q & full_i[t];
    assign send    = trig_sel_i[t] & ~pend_q & ~full_i[t];
    assign hit     = fetch_sel_i[t] & pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        fet_q  <= 1'b0;
        col_q  <= 1'b0;
        stl_q  <= 1'b0;
      end else begin
        if (send)     pend_q <= 1'b1;
        else if (hit) pend_q <= 1'b0;

        if (hit)                   fet_q <= 1'b1;
        else if (clr_fetched_i[t]) fet_q <= 1'b0;

        if (col_set)               col_q <= 1'b1;
        else if (clr_collide_i[t]) col_q <= 1'b0;

        if (stl_set)               stl_q <= 1'b1;
        else if (clr_stall_i[t])   stl_q <= 1'b0;
      end
    end

    assign send_o[t]    = send;
    assign pending_o[t] = pend_q;
    assign fetched_o[t] = fet_q;
    assign collide_o[t] = col_q;
    assign stall_o[t]   = stl_q;
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_send_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             clr_i,
  output logic             pend_o
);
  logic [N_SRC-1:0] live, live_q;
  logic             pend_q;

  assign live = src_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      pend_q <= 1'b0;
    end else begin
      live_q <= live;
      if (|(live & ~live_q)) pend_q <= 1'b1;
      else if (clr_i)        pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/mbox_send_unit.sv
module mbox_send_unit
  import mbox_send_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned MSG_W   = 64,
  localparam int unsigned ID_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_TGT-1:0] tgt_valid_o,
  output logic [MSG_W-1:0]   tgt_msg_o,
  input  logic [NUM_TGT-1:0] tgt_full_i,
  input  logic               fetch_i,
  input  logic [ID_W-1:0]    fetch_id_i,
  output logic               irq_o
);
  logic [ID_W-1:0]    id;
  logic [MSG_W-1:0]   msg;
  logic [N_SRC-1:0]   mask, src;
  logic               trig, clr, irq_clr, pend;
  logic [NUM_TGT-1:0] trig_sel, fetch_sel, send;
  logic [NUM_TGT-1:0] pending_q, fetched_q, collide_q, stall_q;
  logic [NUM_TGT-1:0] clr_fet, clr_col, clr_stl;
  status_t            status;
  logic [NUM_TGT-1:0] valid_q;
  logic [MSG_W-1:0]   msg_q;

  mbox_regs #(.NUM_TGT(NUM_TGT), .MSG_W(MSG_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .id_o(id), .msg_o(msg), .mask_o(mask), .trig_o(trig), .clr_o(clr),
    .irq_clr_o(irq_clr), .status_i(status), .pend_i(pend)
  );

  always_comb begin
    trig_sel  = '0;
    fetch_sel = '0;
    if (trig)    trig_sel[id]          = 1'b1;
    if (fetch_i) fetch_sel[fetch_id_i] = 1'b1;
  end

  assign clr_fet = clr ? wdata_i[2*FIELD_W +: NUM_TGT] : '0;
  assign clr_col = clr ? wdata_i[1*FIELD_W +: NUM_TGT] : '0;
  assign clr_stl = clr ? wdata_i[3*FIELD_W +: NUM_TGT] : '0;

  mbox_tgt_track #(.NUM_TGT(NUM_TGT)) u_track (
    .clk_i, .rst_ni,
    .trig_sel_i(trig_sel), .full_i(tgt_full_i), .fetch_sel_i(fetch_sel),
    .clr_fetched_i(clr_fet), .clr_collide_i(clr_col), .clr_stall_i(clr_stl),
    .send_o(send), .pending_o(pending_q), .fetched_o(fetched_q),
    .collide_o(collide_q), .stall_o(stall_q)
  );

  always_comb begin
    status = '0;
    status.pending[NUM_TGT-1:0] = pending_q;
    status.collide[NUM_TGT-1:0] = collide_q;
    status.fetched[NUM_TGT-1:0] = fetched_q;
    status.stall[NUM_TGT-1:0]   = stall_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      msg_q   <= '0;
    end else begin
      valid_q <= send;
      if (|send) msg_q <= msg;
    end
  end

  assign tgt_valid_o = valid_q;
  assign tgt_msg_o   = msg_q;

  assign src[SRC_STALL]   = |stall_q;
  assign src[SRC_COLLIDE] = |collide_q;
  assign src[SRC_FETCHED] = |fetched_q;

  mbox_irq u_irq (
    .clk_i, .rst_ni, .src_i(src), .mask_i(mask), .clr_i(irq_clr), .pend_o(pend)
  );

  assign irq_o = pend;
endmodule

// File: rtl/mbox_send_unit_chk.sv
module mbox_send_unit_chk #(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned ID_W    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [5:0]         addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_TGT-1:0] tgt_valid_o,
  input logic               fetch_i,
  input logic [ID_W-1:0]    fetch_id_i,
  input logic               irq_o,
  input logic [NUM_TGT-1:0] pending_q,
  input logic [NUM_TGT-1:0] fetched_q,
  input logic [NUM_TGT-1:0] collide_q,
  input logic [2:0]         mask,
  input logic [2:0]         src
);
  // R3
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_valid_o));

  // R3
  strobe_marks_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |tgt_valid_o |-> ((pending_q & tgt_valid_o) == tgt_valid_o));

  // R6
  fetch_retires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i && pending_q[fetch_id_i] |=>
      !pending_q[$past(fetch_id_i)] && fetched_q[$past(fetch_id_i)]);

  // R6
  fetched_needs_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(fetched_q & ~$past(fetched_q)) |-> $past(fetch_i));

  // R4
  collide_needs_trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(collide_q & ~$past(collide_q)) |->
      $past(wr_en_i && addr_i == 6'h0C && wdata_i[0]));

  // R8
  irq_needs_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(src & ~mask)));
endmodule

bind mbox_send_unit mbox_send_unit_chk #(.NUM_TGT(NUM_TGT), .ID_W(ID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .tgt_valid_o(tgt_valid_o), .fetch_i(fetch_i),
  .fetch_id_i(fetch_id_i), .irq_o(irq_o), .pending_q(pending_q),
  .fetched_q(fetched_q), .collide_q(collide_q), .mask(mask), .src(src)
);

// File: tb/test_mbox_send_unit.sv
`timescale 1ns/1ps
module test_mbox_send_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  tgt_valid_o;
  logic [63:0] tgt_msg_o;
  logic [7:0]  tgt_full_i = '0;
  logic        fetch_i = 1'b0;
  logic [2:0]  fetch_id_i = '0;
  logic        irq_o;

  int errors = 0, checks = 0;
  bit done = 0;

  // flag model
  logic [7:0]  m_pend = '0, m_fet = '0, m_col = '0, m_stl = '0;
  logic [2:0]  m_mask = 3'b111, m_prev = '0;
  logic        m_irq = 1'b0;
  logic [2:0]  m_id = '0;
  logic [31:0] m_lo = '0, m_hi = '0;

  always #4 clk_i = ~clk_i;

  mbox_send_unit i_mbox_send_unit (.*);

  function automatic logic [31:0] exp_status();
    return {m_stl, m_fet, m_col, m_pend};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic irq_model();
    logic [2:0] lvl;
    lvl = {|m_fet, |m_col, |m_stl} & ~m_mask;
    if (|(lvl & ~m_prev)) m_irq = 1'b1;
    m_prev = lvl;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic settle_check(input string req);
    logic [31:0] d;
    irq_model();
    @(posedge clk_i);
    @(negedge clk_i);
    rd(6'h14, d);
    chk(req, d, exp_status());
    chk({req, " irq"}, irq_o, m_irq);
  endtask

  task automatic send(input logic [2:0] id, input logic [31:0] lo, input logic [31:0] hi,
                      input string req);
    logic [7:0] ev;
    wr(6'h00, {29'd0, id}); wr(6'h04, lo); wr(6'h08, hi);
    m_id = id; m_lo = lo; m_hi = hi;
    ev = '0;
    if (m_pend[id])            m_col[id] = 1'b1;
    else if (tgt_full_i[id])   m_stl[id] = 1'b1;
    else begin m_pend[id] = 1'b1; ev[id] = 1'b1; end
    wr(6'h0C, 32'h1);
    chk({req, " strobe"}, tgt_valid_o, ev);
    if (|ev) chk({req, " msg"}, tgt_msg_o, {hi, lo});
    @(posedge clk_i); #1;
    chk({req, " strobe width"}, tgt_valid_o, 8'h00);
    @(negedge clk_i);
    settle_check(req);
  endtask

  task automatic fetch(input logic [2:0] id, input string req);
    fetch_i = 1'b1; fetch_id_i = id;
    @(posedge clk_i);
    @(negedge clk_i);
    fetch_i = 1'b0;
    if (m_pend[id]) begin m_pend[id] = 1'b0; m_fet[id] = 1'b1; end
    settle_check(req);
  endtask

  task automatic clear(input logic [31:0] d, input string req);
    wr(6'h10, d);
    m_col &= ~d[15:8]; m_fet &= ~d[23:16]; m_stl &= ~d[31:24];
    settle_check(req);
  endtask

  task automatic set_mask(input logic [2:0] m);
    logic [31:0] d;
    wr(6'h1C, {29'd0, m});
    m_mask = m;
    rd(6'h1C, d);
    chk("R10 mask", d, {29'd0, m});
    settle_check("R8 mask");
  endtask

  task automatic irq_ack();
    logic [31:0] d;
    wr(6'h18, 32'h1);
    m_irq = 1'b0;
    rd(6'h18, d);
    chk("R9 irq status", d, 32'h0);
    settle_check("R9 ack");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0001));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1
    rd(6'h14, d); chk("R1 status", d, 0);
    rd(6'h18, d); chk("R1 irq status", d, 0);
    rd(6'h1C, d); chk("R1 mask", d, 32'h7);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 strobe", tgt_valid_o, 8'h00);

    // R2
    wr(6'h00, 32'hFFFF_FFFD); rd(6'h00, d); chk("R2 id", d, 32'h5);
    wr(6'h04, 32'hA5A5_0001); rd(6'h04, d); chk("R2 low", d, 32'hA5A5_0001);
    wr(6'h08, 32'h1234_5678); rd(6'h08, d); chk("R2 high", d, 32'h1234_5678);
    rd(6'h10, d); chk("R7 clear reads zero", d, 0);

    // R3 trigger with bit0 clear is ignored
    wr(6'h0C, 32'h2);
    chk("R3 no strobe", tgt_valid_o, 8'h00);
    settle_check("R3 ignored trigger");

    // R3 send, masked: no irq
    send(3'd2, 32'hDEAD_BEEF, 32'h0BAD_F00D, "R3 send");
    // R4 collision
    send(3'd2, 32'h1, 32'h2, "R4 collide");
    // R5 stall
    tgt_full_i = 8'h80;
    send(3'd7, 32'h3, 32'h4, "R5 stall");
    tgt_full_i = 8'h00;
    // R6 fetch of idle target ignored, then real fetch
    fetch(3'd4, "R6 idle fetch");
    fetch(3'd2, "R6 fetch");
    // R8 unmask active sources
    set_mask(3'b011);
    irq_ack();
    set_mask(3'b000);
    irq_ack();
    // R7 clear leaves pending
    send(3'd0, 32'h55, 32'h66, "R3 send t0");
    clear(32'hFFFF_FF00, "R7 clear");
    // R8 new source while unmasked
    send(3'd0, 32'h0, 32'h0, "R8 collide irq");
    irq_ack();
    fetch(3'd0, "R6 fetch t0");
    clear(32'hFFFF_FFFF, "R7 clear all");
    irq_ack();

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: send(3'($urandom_range(0, 7)), $urandom, $urandom, "R3 rnd send");
        3, 4:    fetch(3'($urandom_range(0, 7)), "R6 rnd fetch");
        5:       clear($urandom, "R7 rnd clear");
        6:       set_mask(3'($urandom_range(0, 7)));
        7:       irq_ack();
        default: begin
          tgt_full_i = 8'($urandom);
          settle_check("R5 rnd full");
        end
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule